// File: doc/BRIEF.md
# NAND Subpage Read Reassembler

This block takes the decoded byte stream of one large NAND page and sorts it into a page buffer and a spare buffer. The page arrives as four subpages of 528 bytes each. Every subpage holds 512 data bytes, then 6 free spare bytes, then 10 parity bytes. Data bytes go to the page buffer at the subpage's own 512-byte slot. Spare bytes are regrouped so that the free bytes of all four subpages sit together at the front of the 64-byte spare buffer and all parity bytes sit at the back.

With the last byte of each subpage the block also samples that subpage's decoder status word. It keeps the largest corrected-error count seen over the page. In normal mode an uncorrectable subpage ends the page at once with a failure. In spare-only mode, used when only the spare area matters, the data bytes are consumed but not written, and an uncorrectable subpage raises the reported count to 5 while the stream carries on. The block also flags a bad block when either marker byte at the start of the first subpage's free area is not 0xFF.

The host pulses a start input, streams bytes with a valid/ready handshake, and reads the result outputs when the one-cycle done pulse appears.

Top module: `nand_subpage_reasm`

## Requirements
- R1: After a start pulse is accepted while idle, `in_ready_o` is high from the next cycle. A byte is accepted on each rising edge where `in_valid_i` and `in_ready_o` are both high. Bytes are taken as four subpages of 528 bytes: offsets 0-511 data, 512-517 free, 518-527 parity. No write strobe rises unless a byte was accepted on the edge before.
- R2: In normal mode, data byte k of subpage i produces, one cycle after acceptance, a page-buffer write with `pg_addr_o` = 512*i+k and `pg_data_o` equal to the byte. The page and spare write strobes are never high together.
- R3: Free byte j (0..5) of subpage i produces, one cycle after acceptance, a spare-buffer write at `sp_addr_o` = 6*i+j.
- R4: Parity byte j (0..9) of subpage i produces, one cycle after acceptance, a spare-buffer write at `sp_addr_o` = 24+10*i+j.
- R5: The status word `in_stat_i` is sampled with the last byte of each subpage. Bit 3 set means errors were corrected, and the count is then bits 5:4 plus one; with bit 3 clear the count is 0 whatever bits 5:4 hold. `err_cnt_o` is the largest count over the subpages, or 0 when none corrected.
- R6: In spare-only mode (`spare_only_i` high at start), data bytes produce no page-buffer writes, spare writes are as in R3/R4, and a status with bit 6 set forces `err_cnt_o` to 5 without stopping the page and with `fail_o` low. `err_cnt_o` never exceeds 5.
- R7: In normal mode, a status with bit 6 set ends the page. `done_o` and `fail_o` rise in the cycle after that subpage's last byte, and `in_ready_o` drops so no further bytes are accepted. `fail_o` rises only together with `done_o`.
- R8: `bad_blk_o` is 1 when free byte 0 or free byte 1 of subpage 0 is not 0xFF, and 0 otherwise, in either mode.
- R9: `done_o` is a one-cycle pulse in the cycle after the 2112th byte is accepted, with `in_ready_o` low. `err_cnt_o`, `fail_o` and `bad_blk_o` stay valid until the next start.
- R10: A start pulse while the page is in progress has no effect. A start while idle clears the counters and results, and `in_ready_o` rises only in the cycle after a start.
- R11: After reset `in_ready_o`, `done_o`, both write strobes, `fail_o`, `bad_blk_o` and `err_cnt_o` are all 0, and valid bytes offered without a start are not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a page, taken only when idle |
| spare_only_i | input | 1 | Mode for the page being started: 1 = spare-only |
| in_valid_i | input | 1 | Byte offered |
| in_ready_o | output | 1 | Byte can be accepted |
| in_byte_i | input | 8 | Decoded stream byte |
| in_stat_i | input | 8 | Decoder status of the current subpage |
| pg_we_o | output | 1 | Page-buffer write strobe |
| pg_addr_o | output | 11 | Page-buffer byte address |
| pg_data_o | output | 8 | Page-buffer write data |
| sp_we_o | output | 1 | Spare-buffer write strobe |
| sp_addr_o | output | 6 | Spare-buffer byte address |
| sp_data_o | output | 8 | Spare-buffer write data |
| done_o | output | 1 | One-cycle end-of-page pulse |
| fail_o | output | 1 | Page ended on an uncorrectable subpage |
| err_cnt_o | output | 3 | Worst corrected-error count, 5 for a spare-only failure |
| bad_blk_o | output | 1 | Bad-block marker seen |

## Verification
The bench aims at the subpage seams, where an off-by-one in the offset tracker would shift every free and parity byte into the wrong spare slot or leak a byte into the page buffer. It feeds status words that set the count field without the corrected flag, which a design that ignores bit 3 would report as a non-zero count, and an uncorrectable status in both modes: a design that mixes up the modes would abort a spare-only page or run on past a normal failure and keep writing. It gives marker bytes that differ from 0xFF in one position only, to catch a check that looks at just one marker, and it pulses start in the middle of a page, which a design that restarts would answer with a short or misplaced page.

// File: rtl/nsr_pkg.sv
package nsr_pkg;

    // Region of the current byte inside its subpage
    typedef enum logic [1:0] {
        SEG_DATA = 2'd0,
        SEG_FREE = 2'd1,
        SEG_PAR  = 2'd2
    } seg_e;

    // Status word bit positions (behavioural, decoded by this block)
    localparam int ST_CORR_BIT = 3;
    localparam int ST_CNT_LSB  = 4;
    localparam int ST_FAIL_BIT = 6;

    // Count reported for an uncorrectable subpage in spare-only mode
    localparam int FAIL_COUNT = 5;
    localparam int CNT_W      = 3;

endpackage

// File: rtl/nsr_pos_track.sv
module nsr_pos_track
    import nsr_pkg::*;
#(
    parameter int DATA_BYTES = 512,
    parameter int FREE_BYTES = 6,
    parameter int PAR_BYTES  = 10,
    parameter int SUBPAGES   = 4,
    parameter int OFF_W      = $clog2(DATA_BYTES + FREE_BYTES + PAR_BYTES),
    parameter int SUB_W      = (SUBPAGES > 1) ? $clog2(SUBPAGES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             adv_i,
    output logic [SUB_W-1:0] sub_o,
    output logic [OFF_W-1:0] off_o,
    output seg_e             seg_o,
    output logic             sub_end_o,
    output logic             page_end_o
);

    localparam int SUB_BYTES = DATA_BYTES + FREE_BYTES + PAR_BYTES;
    localparam logic [OFF_W-1:0] FREE_AT  = OFF_W'(DATA_BYTES);
    localparam logic [OFF_W-1:0] PAR_AT   = OFF_W'(DATA_BYTES + FREE_BYTES);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(SUB_BYTES - 1);
    localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(SUBPAGES - 1);

    typedef struct packed {
        logic [SUB_W-1:0] sub;
        logic [OFF_W-1:0] off;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (clr_i) begin
            pos_d = '0;
        end else if (adv_i) begin
            if (pos_q.off == LAST_OFF) begin
                pos_d.off = '0;
                pos_d.sub = (pos_q.sub == LAST_SUB) ? '0 : pos_q.sub + 1'b1;
            end else begin
                pos_d.off = pos_q.off + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    always_comb begin
        if (pos_q.off < FREE_AT)     seg_o = SEG_DATA;
        else if (pos_q.off < PAR_AT) seg_o = SEG_FREE;
        else                         seg_o = SEG_PAR;
    end

    assign sub_o      = pos_q.sub;
    assign off_o      = pos_q.off;
    assign sub_end_o  = (pos_q.off == LAST_OFF);
    assign page_end_o = sub_end_o && (pos_q.sub == LAST_SUB);

endmodule

// File: rtl/nsr_addr_map.sv
module nsr_addr_map
    import nsr_pkg::*;
#(
    parameter int DATA_BYTES = 512,
    parameter int FREE_BYTES = 6,
    parameter int PAR_BYTES  = 10,
    parameter int SUBPAGES   = 4,
    parameter int OFF_W      = 10,
    parameter int SUB_W      = 2,
    parameter int PG_AW      = 11,
    parameter int SP_AW      = 6
) (
    input  logic [SUB_W-1:0] sub_i,
    input  logic [OFF_W-1:0] off_i,
    input  seg_e             seg_i,
    output logic [PG_AW-1:0] pg_addr_o,
    output logic [SP_AW-1:0] sp_addr_o
);

    // All free bytes of the page come first, parity follows
    localparam int PAR_BASE = SUBPAGES * FREE_BYTES;

    logic [31:0] sub_w, off_w;

    assign sub_w = 32'(sub_i);
    assign off_w = 32'(off_i);

    assign pg_addr_o = PG_AW'(sub_w * 32'(DATA_BYTES) + off_w);

    always_comb begin
        case (seg_i)
            SEG_FREE: sp_addr_o = SP_AW'(sub_w * 32'(FREE_BYTES) + off_w
                                         - 32'(DATA_BYTES));
            SEG_PAR:  sp_addr_o = SP_AW'(32'(PAR_BASE) + sub_w * 32'(PAR_BYTES)
                                         + off_w - 32'(DATA_BYTES + FREE_BYTES));
            default:  sp_addr_o = '0;
        endcase
    end

endmodule

// File: rtl/nsr_err_acc.sv
module nsr_err_acc
    import nsr_pkg::*;
#(
    parameter int ST_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             take_i,
    input  logic [ST_W-1:0]  stat_i,
    input  logic             soft_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hard_fail_o
);

    localparam logic [CNT_W-1:0] FAIL_CNT = CNT_W'(FAIL_COUNT);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] this_cnt;
    logic             uncorr;

    assign uncorr = stat_i[ST_FAIL_BIT];

    always_comb begin
        if (stat_i[ST_CORR_BIT])
            this_cnt = CNT_W'(stat_i[ST_CNT_LSB +: 2]) + 1'b1;
        else
            this_cnt = '0;
    end

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (take_i) begin
            if (uncorr && soft_i)      cnt_d = FAIL_CNT;
            else if (this_cnt > cnt_q) cnt_d = this_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o       = cnt_q;
    assign hard_fail_o = take_i && uncorr && !soft_i;

    logic unused_stat;
    assign unused_stat = ^{stat_i[ST_W-1:ST_FAIL_BIT+1], stat_i[ST_CORR_BIT-1:0]};

endmodule

// File: rtl/nand_subpage_reasm.sv
module nand_subpage_reasm
    import nsr_pkg::*;
#(
    parameter int DATA_BYTES  = 512,
    parameter int FREE_BYTES  = 6,
    parameter int PAR_BYTES   = 10,
    parameter int SUBPAGES    = 4,
    parameter int ST_W        = 8,
    localparam int SUB_BYTES  = DATA_BYTES + FREE_BYTES + PAR_BYTES,
    localparam int PG_AW      = $clog2(SUBPAGES * DATA_BYTES),
    localparam int SP_AW      = $clog2(SUBPAGES * (FREE_BYTES + PAR_BYTES)),
    localparam int OFF_W      = $clog2(SUB_BYTES),
    localparam int SUB_W      = (SUBPAGES > 1) ? $clog2(SUBPAGES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             spare_only_i,
    input  logic             in_valid_i,
    output logic             in_ready_o,
    input  logic [7:0]       in_byte_i,
    input  logic [ST_W-1:0]  in_stat_i,
    output logic             pg_we_o,
    output logic [PG_AW-1:0] pg_addr_o,
    output logic [7:0]       pg_data_o,
    output logic             sp_we_o,
    output logic [SP_AW-1:0] sp_addr_o,
    output logic [7:0]       sp_data_o,
    output logic             done_o,
    output logic             fail_o,
    output logic [CNT_W-1:0] err_cnt_o,
    output logic             bad_blk_o
);

    // Offsets of the two bad-block marker bytes in subpage 0
    localparam logic [OFF_W-1:0] MARK0 = OFF_W'(DATA_BYTES);
    localparam logic [OFF_W-1:0] MARK1 = OFF_W'(DATA_BYTES + 1);

    typedef struct packed {
        logic             busy;
        logic             spare;
        logic             pg_we;
        logic [PG_AW-1:0] pg_addr;
        logic             sp_we;
        logic [SP_AW-1:0] sp_addr;
        logic [7:0]       wdata;
        logic             done;
        logic             fail;
        logic             bad;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             go, accept;
    logic [SUB_W-1:0] cur_sub;
    logic [OFF_W-1:0] cur_off;
    seg_e             cur_seg;
    logic             sub_end, page_end;
    logic [PG_AW-1:0] map_pg;
    logic [SP_AW-1:0] map_sp;
    logic             hard_fail;

    assign go     = start_i && !ctl_q.busy;
    assign accept = in_valid_i && ctl_q.busy;

    nsr_pos_track #(
        .DATA_BYTES(DATA_BYTES), .FREE_BYTES(FREE_BYTES), .PAR_BYTES(PAR_BYTES),
        .SUBPAGES(SUBPAGES), .OFF_W(OFF_W), .SUB_W(SUB_W)
    ) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (go),
        .adv_i      (accept),
        .sub_o      (cur_sub),
        .off_o      (cur_off),
        .seg_o      (cur_seg),
        .sub_end_o  (sub_end),
        .page_end_o (page_end)
    );

    nsr_addr_map #(
        .DATA_BYTES(DATA_BYTES), .FREE_BYTES(FREE_BYTES), .PAR_BYTES(PAR_BYTES),
        .SUBPAGES(SUBPAGES), .OFF_W(OFF_W), .SUB_W(SUB_W),
        .PG_AW(PG_AW), .SP_AW(SP_AW)
    ) u_map (
        .sub_i     (cur_sub),
        .off_i     (cur_off),
        .seg_i     (cur_seg),
        .pg_addr_o (map_pg),
        .sp_addr_o (map_sp)
    );

    nsr_err_acc #(
        .ST_W(ST_W)
    ) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (go),
        .take_i      (accept && sub_end),
        .stat_i      (in_stat_i),
        .soft_i      (ctl_q.spare),
        .cnt_o       (err_cnt_o),
        .hard_fail_o (hard_fail)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.pg_we = 1'b0;
        ctl_d.sp_we = 1'b0;
        ctl_d.done  = 1'b0;

        if (go) begin
            ctl_d.busy  = 1'b1;
            ctl_d.spare = spare_only_i;
            ctl_d.fail  = 1'b0;
            ctl_d.bad   = 1'b0;
        end

        if (accept) begin
            ctl_d.wdata = in_byte_i;
            case (cur_seg)
                SEG_DATA: begin
                    if (!ctl_q.spare) begin
                        ctl_d.pg_we   = 1'b1;
                        ctl_d.pg_addr = map_pg;
                    end
                end
                SEG_FREE: begin
                    ctl_d.sp_we   = 1'b1;
                    ctl_d.sp_addr = map_sp;
                    if ((cur_sub == '0) && ((cur_off == MARK0) || (cur_off == MARK1))
                        && (in_byte_i != 8'hFF))
                        ctl_d.bad = 1'b1;
                end
                default: begin
                    ctl_d.sp_we   = 1'b1;
                    ctl_d.sp_addr = map_sp;
                end
            endcase

            if (hard_fail) begin
                ctl_d.busy = 1'b0;
                ctl_d.done = 1'b1;
                ctl_d.fail = 1'b1;
            end else if (page_end) begin
                ctl_d.busy = 1'b0;
                ctl_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign in_ready_o = ctl_q.busy;
    assign pg_we_o    = ctl_q.pg_we;
    assign pg_addr_o  = ctl_q.pg_addr;
    assign pg_data_o  = ctl_q.wdata;
    assign sp_we_o    = ctl_q.sp_we;
    assign sp_addr_o  = ctl_q.sp_addr;
    assign sp_data_o  = ctl_q.wdata;
    assign done_o     = ctl_q.done;
    assign fail_o     = ctl_q.fail;
    assign bad_blk_o  = ctl_q.bad;

endmodule

// File: rtl/nsr_checker.sv
module nsr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       in_valid_i,
    input logic       in_ready_o,
    input logic       pg_we_o,
    input logic       sp_we_o,
    input logic       done_o,
    input logic       fail_o,
    input logic [2:0] err_cnt_o
);

    AST_WR_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_we_o || sp_we_o) |-> $past(in_valid_i && in_ready_o)); // R1

    AST_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pg_we_o && sp_we_o)); // R2

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt_o <= 3'd5); // R6

    AST_FAIL_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_o) |-> done_o); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !in_ready_o); // R9

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready_o && start_i) |=> (in_ready_o || done_o)); // R10

    AST_READY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready_o) |-> $past(start_i)); // R10

endmodule

bind nand_subpage_reasm nsr_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .pg_we_o    (pg_we_o),
    .sp_we_o    (sp_we_o),
    .done_o     (done_o),
    .fail_o     (fail_o),
    .err_cnt_o  (err_cnt_o)
);

// File: tb/nand_subpage_reasm_tb_top.sv
module nand_subpage_reasm_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       spare_only_i = 1'b0;
    logic       in_valid_i = 1'b0;
    logic       in_ready_o;
    logic [7:0] in_byte_i = 8'h00;
    logic [7:0] in_stat_i = 8'h00;
    logic       pg_we_o, sp_we_o, done_o, fail_o, bad_blk_o;
    logic [10:0] pg_addr_o;
    logic [5:0]  sp_addr_o;
    logic [7:0]  pg_data_o, sp_data_o;
    logic [2:0]  err_cnt_o;

    always #5 clk = ~clk;

    nand_subpage_reasm dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .spare_only_i(spare_only_i),
        .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_byte_i(in_byte_i),
        .in_stat_i(in_stat_i), .pg_we_o(pg_we_o), .pg_addr_o(pg_addr_o),
        .pg_data_o(pg_data_o), .sp_we_o(sp_we_o), .sp_addr_o(sp_addr_o),
        .sp_data_o(sp_data_o), .done_o(done_o), .fail_o(fail_o),
        .err_cnt_o(err_cnt_o), .bad_blk_o(bad_blk_o)
    );

    int total = 0;
    int bad = 0;
    int cycles = 0;

    typedef struct packed {
        logic       spare;
        logic       mid_start;
        logic [7:0] s0, s1, s2, s3;
        logic [7:0] b0, b1;
        logic [2:0] cnt;
        logic       fail;
        logic       bbm;
        logic [1:0] abort_sub;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, 3'd0, 1'b0, 1'b0, 2'd0},
        '{1'b0, 1'b1, 8'h08, 8'h18, 8'h38, 8'h28, 8'h00, 8'hFF, 3'd4, 1'b0, 1'b1, 2'd0},
        '{1'b0, 1'b0, 8'h00, 8'h18, 8'h00, 8'h00, 8'hFF, 8'h7F, 3'd2, 1'b0, 1'b1, 2'd0},
        '{1'b1, 1'b0, 8'h00, 8'h40, 8'h08, 8'h00, 8'hFF, 8'hFF, 3'd5, 1'b0, 1'b0, 2'd0},
        '{1'b1, 1'b0, 8'h18, 8'h08, 8'h00, 8'h00, 8'h5A, 8'hFF, 3'd2, 1'b0, 1'b1, 2'd0},
        '{1'b0, 1'b0, 8'h08, 8'h00, 8'h40, 8'h00, 8'hFF, 8'hFF, 3'd1, 1'b1, 1'b0, 2'd2},
        '{1'b0, 1'b0, 8'h30, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, 3'd0, 1'b0, 1'b0, 2'd0}
    };

    logic [7:0] pg_mem [2048];
    logic [7:0] sp_mem [64];
    int pg_n = 0;
    int sp_n = 0;

    always @(negedge clk) begin
        if (pg_we_o) begin pg_mem[pg_addr_o] = pg_data_o; pg_n++; end
        if (sp_we_o) begin sp_mem[sp_addr_o] = sp_data_o; sp_n++; end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_of(input int s, input int o,
                                           input logic [7:0] b0, input logic [7:0] b1);
        if (s == 0 && o == 512) return b0;
        if (s == 0 && o == 513) return b1;
        return 8'((s * 37 + o * 7 + 1) & 255);
    endfunction

    function automatic logic [7:0] stat_of(input vec_t t, input int s);
        case (s)
            0: return t.s0;
            1: return t.s1;
            2: return t.s2;
            default: return t.s3;
        endcase
    endfunction

    task automatic run_page(input int v);
        vec_t t = VECS[v];
        int idx = 0;
        int cyc = 0;
        bit seen = 0;
        bit acc;
        int exp_acc;
        int mism;
        pg_n = 0;
        sp_n = 0;
        @(negedge clk);
        start_i = 1'b1;
        spare_only_i = t.spare;
        @(negedge clk);
        start_i = 1'b0;
        chk("R1", "ready after start", 32'(in_ready_o), 32'd1);
        while (idx < 2112 && !seen) begin
            in_byte_i  = byte_of(idx / 528, idx % 528, t.b0, t.b1);
            in_stat_i  = stat_of(t, idx / 528);
            in_valid_i = ((cyc % (3 + v)) != 1);
            start_i    = (t.mid_start && idx == 100);
            acc = in_valid_i && in_ready_o;
            @(negedge clk);
            if (acc) idx++;
            cyc++;
            if (done_o) seen = 1;
        end
        in_valid_i = 1'b0;
        start_i = 1'b0;
        exp_acc = t.fail ? 528 * (int'(t.abort_sub) + 1) : 2112;
        chk("R9", "done pulse after last byte", 32'(seen), 32'd1);
        chk("R7", "fail flag", 32'(fail_o), 32'(t.fail));
        chk("R7", "bytes accepted", 32'(idx), 32'(exp_acc));
        chk("R9", "ready low at done", 32'(in_ready_o), 32'd0);
        if (!t.fail) chk("R5", "error count", 32'(err_cnt_o), 32'(t.cnt));
        chk("R8", "bad block flag", 32'(bad_blk_o), 32'(t.bbm));
        @(negedge clk);
        chk("R9", "done is one cycle", 32'(done_o), 32'd0);
        if (t.spare) begin
            chk("R6", "no page writes in spare mode", 32'(pg_n), 32'd0);
        end else begin
            chk("R2", "page write count", 32'(pg_n), 32'(exp_acc / 528 * 512));
        end
        if (!t.fail) begin
            chk("R3", "spare write count", 32'(sp_n), 32'd64);
            if (!t.spare) begin
                mism = 0;
                for (int a = 0; a < 2048; a++)
                    if (pg_mem[a] !== byte_of(a / 512, a % 512, t.b0, t.b1)) mism++;
                chk("R2", "page buffer mismatches", 32'(mism), 32'd0);
            end
            mism = 0;
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 6; j++)
                    if (sp_mem[6 * i + j] !== byte_of(i, 512 + j, t.b0, t.b1)) mism++;
            chk("R3", "free byte mismatches", 32'(mism), 32'd0);
            mism = 0;
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 10; j++)
                    if (sp_mem[24 + 10 * i + j] !== byte_of(i, 518 + j, t.b0, t.b1)) mism++;
            chk("R4", "parity byte mismatches", 32'(mism), 32'd0);
        end
        if (t.spare) chk("R6", "spare-mode fail flag", 32'(fail_o), 32'd0);
        repeat (3) @(negedge clk);
        chk("R9", "result held", 32'({fail_o, bad_blk_o, err_cnt_o}),
            32'({t.fail, t.bbm, t.fail ? err_cnt_o : t.cnt}));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL R9 watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11", "reset outputs",
            32'({in_ready_o, done_o, pg_we_o, sp_we_o, fail_o, bad_blk_o, err_cnt_o}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        in_valid_i = 1'b1;
        repeat (5) @(negedge clk);
        chk("R11", "no accept without start", 32'(pg_n + sp_n), 32'd0);
        chk("R10", "ready stays low without start", 32'(in_ready_o), 32'd0);
        in_valid_i = 1'b0;
        for (int v = 0; v < NV; v++) run_page(v);
        chk("R10", "next page clears results",
            32'({fail_o, bad_blk_o, err_cnt_o}), 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule